// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block keeps the two-level status hierarchy of an instrument controller. Event pulses from elsewhere in the instrument set bits in a sticky 8-bit event register. An event enable mask reduces that register to a single summary bit, which sits at position 5 of the status byte. The other condition bits of the status byte arrive as live levels on an input. A second mask, the service request enable, reduces the status byte to a master summary at bit 6. A rising edge of that master summary raises a request flag, and the flag drives the service request output.

The controller side reaches the block through a small register port. A 2-bit select picks a register, and separate write, read and clear strobes act on it. Both masks can be read, written and cleared. The event register can be read, and it can be cleared either by a destructive read or by a clear strobe. The status byte can be read with no side effect, and its bit 6 then shows the live master summary. A serial-poll strobe returns the status byte with the request flag in bit 6 in place of the master summary, and it clears that flag.

Top module: `status_report_core`

## Requirements
- R1: After reset, both masks, the event register and the request flag read zero, and `srq` is low.
- R2: An event register bit is set by a one-cycle pulse on the matching bit of `evt_pulse` and stays set until that register is cleared (sel 2 with `reg_rd` or `reg_clr`). A pulse in the clear cycle survives the clear.
- R3: Status byte bit 5 equals the OR over all positions of (event register AND event enable mask).
- R4: Writing or clearing the event enable mask (sel 0) leaves the event register unchanged.
- R5: Status byte bit 6, as read through sel 3, equals the OR of (status byte AND service request enable), with bit 6 excluded. Enable bit 6 alone never produces a summary.
- R6: Each mask (sel 0 event enable, sel 1 service request enable) is written from `reg_wdata` on `reg_wr`, cleared to zero on `reg_clr`, and read on `reg_rdata` while selected.
- R7: Changing the service request enable mask leaves status byte bits 0 to 5 and 7 unchanged.
- R8: The request flag is set in the cycle after the master summary goes from 0 to 1. It then stays set until a serial poll, and `srq` equals the flag.
- R9: `spoll_data` returns status byte bits 0 to 5 and 7 live and the request flag in bit 6. A cycle with `spoll` high clears the flag at the next edge, while the sel 3 read of bit 6 keeps its live master summary.
- R10: The summaries are not latched. Clearing the event register removes bit 5, and it also removes bit 6 when bit 5 was the only cause.
- R11: Status byte bits 0 to 4 and 7 follow `stb_cond` combinationally. `stb_cond` bits 5 and 6 are ignored.
- R12: Register map: sel 0 is the event enable, sel 1 the service request enable, sel 2 the event register, sel 3 the status byte. A read of sel 2 returns the old value in the same cycle as the clear. Writes to sel 2 and sel 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 8 | One-cycle event pulses, one per event register bit |
| stb_cond | input | 8 | Live status byte conditions; bits 5 and 6 unused |
| reg_sel | input | 2 | Register select (0 event enable, 1 service enable, 2 event register, 3 status byte) |
| reg_wr | input | 1 | Write strobe for the selected mask |
| reg_rd | input | 1 | Read strobe; destructive on sel 2 only |
| reg_clr | input | 1 | Clear strobe for the selected mask or the event register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| spoll | input | 1 | Serial-poll strobe |
| spoll_data | output | 8 | Status byte with the request flag in bit 6 |
| srq | output | 1 | Service request output |

## Verification
The bench goes after the moments when bit 6 plays its two roles. After a poll, the master summary stays high while the flag and `srq` drop, so a design that tied `srq` to the live summary would keep requesting service. An enable mask of bit 6 alone must give no summary, so a design that included bit 6 in its own AND/OR would latch itself on. A destructive read made in the same cycle as a new event must keep that event, so a design that cleared after setting would lose it. The bench also clears the event register and checks that bits 5 and 6 fall with it, which exposes any latched summary, and it writes to the read-only selects, which exposes a decoder that leaks those writes into the masks.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_EVT_EN = 2'd0,
    SEL_SRQ_EN = 2'd1,
    SEL_EVENTS = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  // OR across positions of value AND mask
  function automatic logic masked_any(input logic [BYTE_W-1:0] v,
                                      input logic [BYTE_W-1:0] m);
    return |(v & m);
  endfunction

  // same reduction with one position left out of it
  function automatic logic masked_any_except(input logic [BYTE_W-1:0] v,
                                             input logic [BYTE_W-1:0] m,
                                             input int unsigned       skip);
    logic [BYTE_W-1:0] keep;
    keep = ~(BYTE_W'(1) << skip);
    return |(v & m & keep);
  endfunction

  // overwrite one bit position of a byte
  function automatic logic [BYTE_W-1:0] put_bit(input logic [BYTE_W-1:0] v,
                                                input int unsigned       pos,
                                                input logic              b);
    logic [BYTE_W-1:0] r;
    r = v;
    r[pos] = b;
    return r;
  endfunction
endpackage

// File: rtl/sr_event_latch.sv
module sr_event_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // a set arriving with the clear wins, so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (clr_i ? '0 : q) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/sr_mask_bank.sv
module sr_mask_bank #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_en,
  input  logic [N-1:0]        clr_en,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] mask_o
);
  for (genvar g = 0; g < N; g++) begin : g_mask
    logic [W-1:0] m;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         m <= '0;
      else if (clr_en[g]) m <= '0;
      else if (wr_en[g])  m <= wdata;
    end
    assign mask_o[g] = m;
  end
endmodule

// File: rtl/sr_service_ctrl.sv
module sr_service_ctrl
  import status_pkg::*;
#(
  parameter int unsigned MSS_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] stb_base,
  input  logic [BYTE_W-1:0] srq_en,
  input  logic              spoll,
  output logic              mss_o,
  output logic              mss_rise_o,
  output logic              rqs_o
);
  logic mss, mss_q, rqs;

  assign mss = masked_any_except(stb_base, srq_en, MSS_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mss_q <= 1'b0;
    else        mss_q <= mss;
  end

  assign mss_rise_o = mss & ~mss_q;

  // a new rising edge outranks a poll in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rqs <= 1'b0;
    else if (mss_rise_o) rqs <= 1'b1;
    else if (spoll)      rqs <= 1'b0;
  end

  assign mss_o = mss;
  assign rqs_o = rqs;
endmodule

// File: rtl/status_report_core.sv
module status_report_core
  import status_pkg::*;
#(
  parameter int unsigned ESB_BIT = 5,
  parameter int unsigned MSS_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] evt_pulse,
  input  logic [BYTE_W-1:0] stb_cond,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_clr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              spoll,
  output logic [BYTE_W-1:0] spoll_data,
  output logic              srq
);
  localparam int N_MASK  = 2;
  localparam int IDX_EVT = 0;
  localparam int IDX_SRQ = 1;

  // named internal events, brought out for the checker
  logic [N_MASK-1:0]             mask_wr, mask_clr;
  logic [N_MASK-1:0][BYTE_W-1:0] masks;
  logic [BYTE_W-1:0]             ese_q, sre_q, esr_q;
  logic [BYTE_W-1:0]             stb_base, stb_live;
  logic                          esr_clr, esb, mss, mss_rise, rqs_q;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  always_comb begin
    mask_wr  = '0;
    mask_clr = '0;
    mask_wr[IDX_EVT]  = reg_wr  && (sel == SEL_EVT_EN);
    mask_wr[IDX_SRQ]  = reg_wr  && (sel == SEL_SRQ_EN);
    mask_clr[IDX_EVT] = reg_clr && (sel == SEL_EVT_EN);
    mask_clr[IDX_SRQ] = reg_clr && (sel == SEL_SRQ_EN);
  end

  assign esr_clr = (reg_rd || reg_clr) && (sel == SEL_EVENTS);

  sr_mask_bank #(.W(BYTE_W), .N(N_MASK)) u_masks (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .clr_en (mask_clr),
    .wdata  (reg_wdata),
    .mask_o (masks)
  );

  assign ese_q = masks[IDX_EVT];
  assign sre_q = masks[IDX_SRQ];

  sr_event_latch #(.W(BYTE_W)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_pulse),
    .clr_i (esr_clr),
    .q_o   (esr_q)
  );

  assign esb = masked_any(esr_q, ese_q);

  // conditions from outside, with the two summary positions owned here
  always_comb begin
    stb_base = put_bit(stb_cond, MSS_BIT, 1'b0);
    stb_base = put_bit(stb_base, ESB_BIT, esb);
  end

  sr_service_ctrl #(.MSS_BIT(MSS_BIT)) u_srv (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_base   (stb_base),
    .srq_en     (sre_q),
    .spoll      (spoll),
    .mss_o      (mss),
    .mss_rise_o (mss_rise),
    .rqs_o      (rqs_q)
  );

  assign stb_live   = put_bit(stb_base, MSS_BIT, mss);
  assign spoll_data = put_bit(stb_base, MSS_BIT, rqs_q);
  assign srq        = rqs_q;

  always_comb begin
    unique case (sel)
      SEL_EVT_EN: reg_rdata = ese_q;
      SEL_SRQ_EN: reg_rdata = sre_q;
      SEL_EVENTS: reg_rdata = esr_q;
      default:    reg_rdata = stb_live;
    endcase
  end
endmodule

// File: rtl/status_report_checks.sv
module status_report_checks
  import status_pkg::*;
#(
  parameter int unsigned ESB_BIT = 5,
  parameter int unsigned MSS_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BYTE_W-1:0] evt_pulse,
  input logic [BYTE_W-1:0] esr_q,
  input logic [BYTE_W-1:0] ese_q,
  input logic [BYTE_W-1:0] sre_q,
  input logic [1:0]        mask_wr,
  input logic [1:0]        mask_clr,
  input logic              esr_clr,
  input logic              mss,
  input logic              mss_rise,
  input logic              spoll,
  input logic              srq,
  input logic [BYTE_W-1:0] stb_live
);
  localparam logic [BYTE_W-1:0] NO_MSS = ~(BYTE_W'(1) << MSS_BIT);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((esr_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_esr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !esr_clr |=> ((esr_q & $past(esr_q)) == $past(esr_q)));

  p_esb_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ese_q == '0) |-> !stb_live[ESB_BIT]);

  p_mask_keeps_esr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_wr[0] || mask_clr[0]) && !esr_clr && evt_pulse == '0) |=> $stable(esr_q));

  p_bit6_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sre_q & NO_MSS) == '0) |-> !mss);

  p_rise_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mss_rise |=> srq);

  p_srq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srq && !spoll) |=> srq);

  p_poll_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spoll && !mss_rise) |=> !srq);

  p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_clr && evt_pulse == '0) |=> (esr_q == '0 && !stb_live[ESB_BIT]));
endmodule

bind status_report_core status_report_checks #(
  .ESB_BIT (ESB_BIT),
  .MSS_BIT (MSS_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_pulse (evt_pulse),
  .esr_q     (esr_q),
  .ese_q     (ese_q),
  .sre_q     (sre_q),
  .mask_wr   (mask_wr),
  .mask_clr  (mask_clr),
  .esr_clr   (esr_clr),
  .mss       (mss),
  .mss_rise  (mss_rise),
  .spoll     (spoll),
  .srq       (srq),
  .stb_live  (stb_live)
);

// File: tb/status_report_core_bench.sv
`timescale 1ns/1ps
module status_report_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_pulse = '0, stb_cond = '0, reg_wdata = '0;
  logic [1:0] reg_sel = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_clr = 1'b0, spoll = 1'b0;
  logic [7:0] reg_rdata, spoll_data;
  logic       srq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  status_report_core u_status_report_core (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .stb_cond(stb_cond),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_clr(reg_clr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spoll(spoll),
    .spoll_data(spoll_data), .srq(srq)
  );

  // op: 0 idle, 1 write, 2 read, 3 clear
  // fields: op[44:43] sel[42:41] wdata[40:33] evt[32:25] cond[24:17]
  //         exp_esr[16:9] exp_stb[8:1] exp_srq[0]
  localparam int NV = 11;
  localparam logic [44:0] VECS [NV] = '{
    {2'd1, 2'd0, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
    {2'd1, 2'd1, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
    {2'd0, 2'd0, 8'h00, 8'h08, 8'h00, 8'h08, 8'h60, 1'b1},
    {2'd0, 2'd0, 8'h00, 8'h02, 8'h00, 8'h0A, 8'h60, 1'b1},
    {2'd1, 2'd0, 8'h02, 8'h00, 8'h00, 8'h0A, 8'h60, 1'b1},
    {2'd3, 2'd0, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 1'b1},
    {2'd0, 2'd0, 8'h00, 8'h00, 8'h81, 8'h0A, 8'h81, 1'b1},
    {2'd1, 2'd1, 8'hC1, 8'h00, 8'h81, 8'h0A, 8'hC1, 1'b1},
    {2'd1, 2'd1, 8'h40, 8'h00, 8'h81, 8'h0A, 8'h81, 1'b1},
    {2'd0, 2'd0, 8'h00, 8'h00, 8'h60, 8'h0A, 8'h00, 1'b1},
    {2'd2, 2'd2, 8'h00, 8'h00, 8'h60, 8'h00, 8'h00, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr = 0; reg_rd = 0; reg_clr = 0; spoll = 0; evt_pulse = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic do_reset();
    idle_inputs();
    stb_cond = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic reg_op(input int op, input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d;
    reg_wr = (op == 1); reg_rd = (op == 2); reg_clr = (op == 3);
    tick();
  endtask

  logic [7:0] v;

  initial begin
    do_reset();
    // R1: everything zero after reset
    for (int s = 0; s < 4; s++) begin
      peek(2'(s), v);
      check($sformatf("R1 sel %0d after reset", s), v, 8'h00);
    end
    check("R1 srq after reset", {7'd0, srq}, 8'h00);
    check("R1 poll data after reset", spoll_data, 8'h00);

    // vector walk: R2 R3 R4 R5 R7 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [44:0] w;
      w = VECS[i];
      reg_sel = w[42:41]; reg_wdata = w[40:33];
      reg_wr = (w[44:43] == 2'd1); reg_rd = (w[44:43] == 2'd2); reg_clr = (w[44:43] == 2'd3);
      evt_pulse = w[32:25]; stb_cond = w[24:17];
      tick();
      tick();
      tick();
      peek(2'd2, v);
      check($sformatf("R2 R4 R12 vec %0d event register", i), v, w[16:9]);
      peek(2'd3, v);
      check($sformatf("R3 R5 R7 R11 vec %0d status byte", i), v, w[8:1]);
      check($sformatf("R8 vec %0d srq", i), {7'd0, srq}, {7'd0, w[0]});
    end

    // R8 and R9: request flag against the live summary
    do_reset();
    reg_op(1, 2'd0, 8'h01);
    reg_op(1, 2'd1, 8'h20);
    peek(2'd1, v);
    check("R6 service enable read back", v, 8'h20);
    evt_pulse = 8'h01;
    tick();
    check("R8 srq not yet set one edge after event", {7'd0, srq}, 8'h00);
    tick();
    check("R8 srq set after summary rise", {7'd0, srq}, 8'h01);
    check("R9 poll data carries flag", spoll_data, 8'h60);
    spoll = 1;
    tick();
    check("R9 srq cleared by poll", {7'd0, srq}, 8'h00);
    check("R9 poll data flag cleared", spoll_data, 8'h20);
    peek(2'd3, v);
    check("R9 live summary still high after poll", v, 8'h60);
    repeat (3) tick();
    check("R8 no new request without new rise", {7'd0, srq}, 8'h00);

    // R12 destructive read returns old value; R10 summaries drop
    reg_sel = 2'd2; reg_rd = 1;
    #0.5;
    check("R12 read returns old event value", reg_rdata, 8'h01);
    tick();
    peek(2'd2, v);
    check("R12 event register cleared by read", v, 8'h00);
    peek(2'd3, v);
    check("R10 bits 5 and 6 drop with clear", v, 8'h00);
    evt_pulse = 8'h01;
    tick();
    tick();
    check("R8 new rise raises srq again", {7'd0, srq}, 8'h01);

    // R2 pulse in the clear cycle survives
    reg_sel = 2'd2; reg_rd = 1; evt_pulse = 8'h04;
    tick();
    peek(2'd2, v);
    check("R2 event kept through clear", v, 8'h04);

    // R12 writes to read-only selects change nothing
    reg_op(1, 2'd2, 8'hFF);
    peek(2'd2, v);
    check("R12 write to event register ignored", v, 8'h04);
    reg_op(1, 2'd3, 8'hFF);
    peek(2'd0, v);
    check("R12 status write leaves event enable", v, 8'h01);
    peek(2'd1, v);
    check("R12 status write leaves service enable", v, 8'h20);

    // R6 clears
    reg_op(3, 2'd1, 8'h00);
    peek(2'd1, v);
    check("R6 service enable cleared", v, 8'h00);
    reg_op(3, 2'd2, 8'h00);
    peek(2'd2, v);
    check("R6 event register clear strobe", v, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule